// File: doc/BRIEF.md
# UART Receive FIFO Controller

This block holds the bytes a UART receiver has deserialized until the host reads them. With the queue switched on it stores up to sixteen bytes in a ring and reports how many are waiting. It decodes a receive trigger level, tells the far end how many more bytes it may send, and raises a character-timeout flag when data has sat unread for four character times. With the queue switched off, a single holding slot stands in for the ring.

It is steered by writes to an eight-bit FIFO control value. Only the enable bit, the DMA-mode bit and the two trigger-select bits are kept. The receive-clear and transmit-clear bits act on the write that carries them and are never stored. Any write that changes the enable bit clears both queues. A write of the value already held does nothing. The transmit-side clear is passed on as a one-cycle pulse for the neighbouring transmit queue.

Top module: `uart_rx_queue`

## Requirements
- R1: After synchronous reset, level is 0 and data_ready, timeout_pend, overrun and tx_flush are 0. The stored control value is 0x00, trig_level is 1 and room is 1.
- R2: With the queue enabled (control bit 0 = 1), accepted bytes come out of rd_byte in arrival order, up to DEPTH bytes. level counts the held bytes and data_ready is 1 exactly when level is not 0. rd_byte shows the oldest byte, and a pulse on rd_strobe removes it at the clock edge.
- R3: When enabled, trig_level decodes control bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. When disabled, trig_level is 1.
- R4: The stored control value keeps only bits 7, 6, 3 and 0 (mask 0xC9). Write bit 1 empties the receive queue. Write bit 2 gives a one-cycle tx_flush pulse in the cycle after the write. Neither bit is retained.
- R5: A control write equal to the stored value changes nothing: the held bytes stay and no tx_flush pulse is produced.
- R6: A control write whose bit 0 differs from the stored bit 0 empties the receive queue and pulses tx_flush, whatever bits 1 and 2 of the written value are.
- R7: When enabled, room is (trig_level − level) while level ≤ trig_level. It is 1 while level is above trig_level and below DEPTH, and 0 at level DEPTH.
- R8: When enabled, each accepted byte restarts an idle count of TIMEOUT_CHARS char_tick pulses. When the count completes and the queue still holds data, timeout_pend becomes 1 at the edge of the last tick.
- R9: A read in enabled mode clears timeout_pend. If the read leaves data behind, it restarts the idle count. Emptying the receive queue by a control write also clears timeout_pend.
- R10: A read from an empty queue returns 0x00 on rd_byte and leaves level at 0.
- R11: A byte that arrives while the queue is at capacity is dropped, level is unchanged and overrun becomes 1. overrun stays 1 until the receive queue is emptied by a control write.
- R12: When disabled, one byte is held. While it is held, room is 0 and a further byte is dropped with overrun set. After it is read, room returns to 1. timeout_pend never rises in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| rd_strobe | input | 1 | Host read: pop the oldest byte |
| rd_byte | output | 8 | Oldest held byte, 0x00 when empty |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| char_tick | input | 1 | One pulse per character time |
| data_ready | output | 1 | At least one byte is held |
| level | output | LVL_W | Number of held bytes |
| trig_level | output | LVL_W | Decoded receive trigger level |
| timeout_pend | output | 1 | Character timeout is pending |
| room | output | LVL_W | Bytes the sender may still deliver |
| overrun | output | 1 | A byte was dropped for lack of space |
| fcr_value | output | 8 | Stored control value (sticky bits only) |
| tx_flush | output | 1 | One-cycle request to clear the transmit queue |

## Verification
The bench builds the block with its default DEPTH of 16 and TIMEOUT_CHARS of 4. At that size, a burst of seventeen bytes reaches the full queue, the dropped byte and the step of room from 1 to 0. Four ticks are enough to show the timeout firing, being pushed back by a new byte, and being rearmed by a read that leaves data behind. Every trigger code, including 14, is within reach of the room formula at that depth.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FCR_KEEP_MASK = 8'hC9;
    localparam logic [BYTE_W-1:0] FCR_BOTH_CLEAR = 8'h06;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    typedef struct packed {
        trig_sel_e  trig_sel;
        logic [1:0] spare;
        logic       dma_mode;
        logic       tx_clear;
        logic       rx_clear;
        logic       enable;
    } fcr_t;

    function automatic int unsigned trig_bytes(input trig_sel_e sel);
        case (sel)
            TRIG_ONE:      return 1;
            TRIG_FOUR:     return 4;
            TRIG_EIGHT:    return 8;
            default:       return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_fcr_ctrl.sv
module rxq_fcr_ctrl
    import uart_rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output fcr_t              q,
    output logic              rx_flush,
    output logic              tx_pulse
);

    logic              act;
    logic [BYTE_W-1:0] eff;

    always_comb begin
        act = wr && (wdata != BYTE_W'(q));
        eff = wdata;
        if (act && (wdata[0] != q.enable)) begin
            eff = wdata | FCR_BOTH_CLEAR;
        end
        rx_flush = act && eff[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            tx_pulse <= 1'b0;
        end else begin
            tx_pulse <= act && eff[2];
            if (act) begin
                q <= fcr_t'(eff & FCR_KEEP_MASK);
            end
        end
    end

endmodule

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             cap_one,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             overrun
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] head, tail, head_nx, tail_nx;
    logic [CNT_W-1:0] cap;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign head_nx = head + 1'b1;
            assign tail_nx = tail + 1'b1;
        end else begin : g_cmp_wrap
            assign head_nx = (head == PTR_W'(DEPTH - 1)) ? '0 : head + 1'b1;
            assign tail_nx = (tail == PTR_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
        end
    endgenerate

    assign cap     = cap_one ? CNT_W'(1) : CNT_W'(DEPTH);
    assign push_ok = push && (count < cap);
    assign pop_ok  = pop && (count != '0);
    assign dout    = (count != '0) ? mem[tail] : '0;

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[head] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head    <= '0;
            tail    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) head <= head_nx;
            if (pop_ok)  tail <= tail_nx;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
            if (push && !push_ok) overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
    parameter int CHARS = 4,
    parameter int TCW   = $clog2(CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic cancel,
    input  logic restart,
    input  logic tick,
    input  logic clear_pend,
    input  logic have_data,
    output logic pend
);

    logic           active;
    logic [TCW-1:0] ticks;
    logic           expire;

    assign expire = active && tick && !restart && !cancel
                    && (ticks == TCW'(CHARS - 1));

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            active <= 1'b0;
            ticks  <= '0;
        end else if (restart) begin
            active <= 1'b1;
            ticks  <= '0;
        end else if (active && tick) begin
            if (expire) begin
                active <= 1'b0;
                ticks  <= '0;
            end else begin
                ticks <= ticks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (clear_pend || cancel) begin
            pend <= 1'b0;
        end else if (expire && have_data) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int TIMEOUT_CHARS = 4,
    parameter int LVL_W         = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic              fcr_wr,
    input  logic [BYTE_W-1:0] fcr_wdata,
    input  logic              char_tick,
    output logic              data_ready,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  trig_level,
    output logic              timeout_pend,
    output logic [LVL_W-1:0]  room,
    output logic              overrun,
    output logic [BYTE_W-1:0] fcr_value,
    output logic              tx_flush
);

    fcr_t fcr_q;
    logic rx_flush;
    logic fifo_en;
    logic push_ok, pop_ok;
    logic restart;

    rxq_fcr_ctrl u_fcr (
        .clk      (clk),
        .rst      (rst),
        .wr       (fcr_wr),
        .wdata    (fcr_wdata),
        .q        (fcr_q),
        .rx_flush (rx_flush),
        .tx_pulse (tx_flush)
    );

    assign fifo_en   = fcr_q.enable;
    assign fcr_value = BYTE_W'(fcr_q);

    rxq_ring #(
        .DEPTH (DEPTH),
        .W     (BYTE_W),
        .CNT_W (LVL_W)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .flush   (rx_flush),
        .cap_one (!fifo_en),
        .push    (rx_valid),
        .din     (rx_byte),
        .pop     (rd_strobe),
        .dout    (rd_byte),
        .count   (level),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .overrun (overrun)
    );

    assign restart = fifo_en && !rx_flush &&
                     (push_ok || (pop_ok && (level > LVL_W'(1))));

    rxq_idle_timer #(
        .CHARS (TIMEOUT_CHARS)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cancel     (rx_flush),
        .restart    (restart),
        .tick       (char_tick),
        .clear_pend (fifo_en && rd_strobe),
        .have_data  (level != '0),
        .pend       (timeout_pend)
    );

    assign data_ready = (level != '0);
    assign trig_level = fifo_en ? LVL_W'(trig_bytes(fcr_q.trig_sel)) : LVL_W'(1);

    always_comb begin
        if (!fifo_en) begin
            room = (level == '0) ? LVL_W'(1) : '0;
        end else if (level <= trig_level) begin
            room = trig_level - level;
        end else if (level < LVL_W'(DEPTH)) begin
            room = LVL_W'(1);
        end else begin
            room = '0;
        end
    end

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rd_strobe,
    input logic             fcr_wr,
    input logic [7:0]       fcr_wdata,
    input logic [7:0]       fcr_value,
    input logic [LVL_W-1:0] level,
    input logic [LVL_W-1:0] room,
    input logic             overrun,
    input logic             timeout_pend
);

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_sticky_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (fcr_value & 8'h36) == 8'h00);

    assert_equal_write_R5: assert property (@(posedge clk) disable iff (rst)
        (fcr_wr && fcr_wdata == fcr_value && !rx_valid && !rd_strobe)
        |=> ($stable(fcr_value) && $stable(level)));

    assert_toggle_flush_R6: assert property (@(posedge clk) disable iff (rst)
        (fcr_wr && fcr_wdata[0] != fcr_value[0])
        |=> (level == '0 && !timeout_pend));

    assert_full_room_R7: assert property (@(posedge clk) disable iff (rst)
        (fcr_value[0] && level == LVL_W'(DEPTH)) |-> room == '0);

    assert_pend_has_data_R9: assert property (@(posedge clk) disable iff (rst)
        timeout_pend |-> level != '0);

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && level == '0 && !rx_valid && !fcr_wr) |=> level == '0);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && level == LVL_W'(DEPTH) && !rd_strobe && !fcr_wr)
        |=> (overrun && level == LVL_W'(DEPTH)));

    assert_single_slot_R12: assert property (@(posedge clk) disable iff (rst)
        !fcr_value[0] |-> level <= LVL_W'(1));

endmodule

bind uart_rx_queue rxq_checker #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rd_strobe    (rd_strobe),
    .fcr_wr       (fcr_wr),
    .fcr_wdata    (fcr_wdata),
    .fcr_value    (fcr_value),
    .level        (level),
    .room         (room),
    .overrun      (overrun),
    .timeout_pend (timeout_pend)
);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LVL_W      = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = '0;
    logic             rd_strobe = 1'b0;
    logic [7:0]       rd_byte;
    logic             fcr_wr = 1'b0;
    logic [7:0]       fcr_wdata = '0;
    logic             char_tick = 1'b0;
    logic             data_ready;
    logic [LVL_W-1:0] level, trig_level, room;
    logic             timeout_pend, overrun, tx_flush;
    logic [7:0]       fcr_value;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_queue #(.DEPTH(DEPTH), .TIMEOUT_CHARS(4)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_strobe(rd_strobe), .rd_byte(rd_byte), .fcr_wr(fcr_wr),
        .fcr_wdata(fcr_wdata), .char_tick(char_tick), .data_ready(data_ready),
        .level(level), .trig_level(trig_level), .timeout_pend(timeout_pend),
        .room(room), .overrun(overrun), .fcr_value(fcr_value), .tx_flush(tx_flush)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [7:0] exp);
        check(req, "rd_byte", rd_byte, exp);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic fcr(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_wdata = v;
        @(negedge clk);
        fcr_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            @(negedge clk);
            char_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R1", "level", level, 0);
        check("R1", "data_ready", data_ready, 0);
        check("R1", "fcr_value", fcr_value, 8'h00);
        check("R1", "trig_level", trig_level, 1);
        check("R1", "room", room, 1);
        check("R1", "pend/overrun/tx_flush", {timeout_pend, overrun, tx_flush}, 0);
    endtask

    task automatic t_order;
        fcr(8'h01);
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
        check("R2", "level", level, 5);
        check("R2", "data_ready", data_ready, 1);
        for (int i = 0; i < 5; i++) pop_expect("R2", 8'hA0 + 8'(i));
        check("R2", "level drained", level, 0);
        check("R2", "data_ready drained", data_ready, 0);
        pop_expect("R10", 8'h00);
        check("R10", "level after empty read", level, 0);
    endtask

    task automatic t_trigger;
        int exp_tbl [4] = '{1, 4, 8, 14};
        for (int c = 0; c < 4; c++) begin
            fcr({2'(c), 6'b000001});
            check("R3", "trig_level", trig_level, exp_tbl[c]);
        end
        push(8'h5A);
        check("R4", "level before clear", level, 1);
        fcr(8'hC7);
        check("R4", "fcr_value sticky", fcr_value, 8'hC1);
        check("R4", "rx cleared", level, 0);
        check("R4", "tx_flush pulse", tx_flush, 1);
        @(negedge clk);
        check("R4", "tx_flush ends", tx_flush, 0);
        fcr(8'hFF);
        check("R4", "fcr_value mask", fcr_value, 8'hC9);
    endtask

    task automatic t_room;
        fcr(8'h41);
        check("R7", "room at 0", room, 4);
        push(8'h00); push(8'h01);
        check("R7", "room at 2", room, 2);
        push(8'h02); push(8'h03);
        check("R7", "room at trigger", room, 0);
        push(8'h04);
        check("R7", "room above trigger", room, 1);
        for (int i = 5; i < 15; i++) push(8'(i));
        check("R7", "room at 15", room, 1);
        push(8'h0F);
        check("R7", "room at full", room, 0);
        check("R2", "level full", level, DEPTH);
        push(8'hEE);
        check("R11", "level after drop", level, DEPTH);
        check("R11", "overrun", overrun, 1);
        pop_expect("R11", 8'h00);
        pop_expect("R11", 8'h01);
        check("R11", "overrun sticky", overrun, 1);
        fcr(8'h43);
        check("R11", "overrun cleared", overrun, 0);
        check("R4", "level after rx clear", level, 0);
        check("R4", "fcr_value after clear", fcr_value, 8'h41);
    endtask

    task automatic t_equal;
        push(8'h61); push(8'h62);
        fcr(8'h41);
        check("R5", "level kept", level, 2);
        check("R5", "no tx_flush", tx_flush, 0);
        check("R5", "fcr_value", fcr_value, 8'h41);
        fcr(8'h40);
        check("R6", "level flushed", level, 0);
        check("R6", "tx_flush on toggle", tx_flush, 1);
        fcr(8'h41);
        check("R6", "tx_flush re-enable", tx_flush, 1);
    endtask

    task automatic t_timeout;
        push(8'h11);
        ticks(3);
        check("R8", "pend after 3 ticks", timeout_pend, 0);
        push(8'h22);
        ticks(3);
        check("R8", "pend after restart", timeout_pend, 0);
        ticks(1);
        check("R8", "pend after 4 ticks", timeout_pend, 1);
        pop_expect("R9", 8'h11);
        check("R9", "pend cleared by read", timeout_pend, 0);
        ticks(3);
        check("R9", "pend 3 ticks after read", timeout_pend, 0);
        ticks(1);
        check("R9", "pend rearmed", timeout_pend, 1);
        fcr(8'h43);
        check("R9", "pend cleared by rx clear", timeout_pend, 0);
        push(8'h33);
        pop_expect("R8", 8'h33);
        ticks(5);
        check("R8", "no pend when empty", timeout_pend, 0);
    endtask

    task automatic t_disabled;
        fcr(8'h40);
        check("R3", "trig_level disabled", trig_level, 1);
        check("R12", "room empty", room, 1);
        push(8'hA1);
        check("R12", "level held", level, 1);
        check("R12", "room held", room, 0);
        push(8'hB2);
        check("R12", "overrun", overrun, 1);
        check("R12", "level after drop", level, 1);
        ticks(5);
        check("R12", "no timeout", timeout_pend, 0);
        pop_expect("R12", 8'hA1);
        check("R12", "room after read", room, 1);
        check("R12", "data_ready after read", data_ready, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_order();
        t_trigger();
        t_room();
        t_equal();
        t_timeout();
        t_disabled();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule